// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

This block sits between a host controller and a card contact set, and forwards open-drain data on several independent channels: one main data line and two auxiliary lines by default. Neither side is told the direction of a transfer. Each channel stays in a neutral state until one of its two lines falls. The side that fell first becomes the source, and the block pulls the opposite line low to copy it. When the source line rises again, the block releases the copied line. It also drives that line actively high for one cycle so that the rising edge does not depend only on the pull-up.

The block takes sampled levels of both lines of every channel, a reception enable from the activation sequencer, a chip select and an active-low reset. Its outputs are per-line pull-low enables and per-line one-cycle push-high enables. The pads, which combine these enables with the external pull-ups, are outside the block. Every output is registered, so an edge seen on a sampled input reaches the opposite side one clock later. At 50 MHz that is 20 ns, which meets both the falling-edge budget of about 100 ns and the rising-edge budget of about 25 ns. While reception is disabled, the card lines are held low. While chip select is low, the host lines are left to their weak pull-ups and nothing is forwarded in either direction.

Top module: `io_dir_arbiter`

## Requirements
- R1: During and directly after reset, with reception disabled, every card-side pull-low enable is 1, every host-side pull-low enable is 0, and all push-high enables are 0.
- R2: One cycle after reception enable is sampled low, every channel holds its card line low and drives nothing else. This applies even if a transfer was in progress, and no push-high pulse is produced.
- R3: One cycle after reception enable is sampled high (with chip select high), every channel is neutral and drives neither line.
- R4: In the neutral state, a host line falling from 1 to 0 while its card line stays high sets that channel's card pull-low enable on the next cycle. The enable stays set until the host line rises.
- R5: In the neutral state, a card line falling while its host line stays high sets that channel's host pull-low enable on the next cycle. The enable stays set until the card line rises.
- R6: If both lines of a neutral channel fall in the same sampled cycle, the card side wins: the host pull-low enable is set.
- R7: When the source line of a transfer rises, the copied line's pull-low enable clears on the next cycle. In that same cycle its push-high enable is 1 for exactly one cycle, and the channel is neutral again.
- R8: While chip select is sampled low with reception enabled, one cycle later no line is driven low or high. Falls seen during that time start no transfer, and a line that is still low when chip select returns starts nothing.
- R9: A line is never driven low and high in the same cycle, and the two lines of a channel are never both driven low.
- R10: Channels are independent: each channel's direction and drives depend only on its own two lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Reception enable from the sequencer |
| cs | input | 1 | Chip select, active high |
| host_lvl | input | NUM_CH | Sampled level of each host-side line |
| card_lvl | input | NUM_CH | Sampled level of each card-side line |
| host_pull_lo | output | NUM_CH | Pull-low enable per host-side line |
| host_push_hi | output | NUM_CH | One-cycle push-high enable per host-side line |
| card_pull_lo | output | NUM_CH | Pull-low enable per card-side line |
| card_push_hi | output | NUM_CH | One-cycle push-high enable per card-side line |

## Verification
The assertions assume that the level inputs are already synchronized to the clock, and that a line the block pulls low reads back as low on the next sample. The bench meets both assumptions by building every sampled level as a wired-AND of the external driver and the block's own pull-low enable, ORed with its push-high enable, computed from registered outputs. External stimulus changes only on the falling clock edge, so every edge the block sees is one clean sample-to-sample transition. Chip select and reception enable are also toggled at those points, including in the middle of a transfer.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    CH_OFF     = 2'd0,
    CH_IDLE    = 2'd1,
    CH_HOST_IN = 2'd2,
    CH_CARD_IN = 2'd3
  } ch_state_t;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_t;

endpackage

// File: rtl/arb_edge.sv
module arb_edge #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level,
  output arb_pkg::edge_t ev
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LEVEL;
    else        prev_q <= level;
  end

  always_comb begin
    ev.fall = prev_q & ~level;
    ev.rise = ~prev_q & level;
  end

endmodule

// File: rtl/arb_drive.sv
module arb_drive (
  input  logic                clk,
  input  logic                rst_n,
  input  arb_pkg::ch_state_t  state,
  input  arb_pkg::ch_state_t  nxt,
  input  logic                leave,
  output logic                host_lo,
  output logic                host_hi,
  output logic                card_lo,
  output logic                card_hi
);
  import arb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_lo <= 1'b1;
      host_lo <= 1'b0;
      card_hi <= 1'b0;
      host_hi <= 1'b0;
    end else begin
      card_lo <= (nxt == CH_OFF) || (nxt == CH_HOST_IN);
      host_lo <= (nxt == CH_CARD_IN);
      card_hi <= leave && (state == CH_HOST_IN);
      host_hi <= leave && (state == CH_CARD_IN);
    end
  end

endmodule

// File: rtl/arb_channel.sv
module arb_channel #(
  parameter logic CARD_FIRST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic cs,
  input  logic host_lvl,
  input  logic card_lvl,
  output logic host_lo,
  output logic host_hi,
  output logic card_lo,
  output logic card_hi
);
  import arb_pkg::*;

  edge_t     host_ev;
  edge_t     card_ev;
  ch_state_t state_q;
  ch_state_t nxt;
  logic      leave;
  logic      take_card;
  logic      take_host;

  arb_edge #(.IDLE_LEVEL(1'b1)) u_host_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (host_lvl),
    .ev    (host_ev)
  );

  // Card lines are held low in reset, so the idle sample is low.
  arb_edge #(.IDLE_LEVEL(1'b0)) u_card_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (card_lvl),
    .ev    (card_ev)
  );

  // Tie-break: the preferred side takes a simultaneous fall.
  always_comb begin
    if (CARD_FIRST) begin
      take_card = card_ev.fall;
      take_host = host_ev.fall && !card_ev.fall;
    end else begin
      take_host = host_ev.fall;
      take_card = card_ev.fall && !host_ev.fall;
    end
  end

  always_comb begin
    nxt   = state_q;
    leave = 1'b0;
    if (!rx_en) begin
      nxt = CH_OFF;
    end else if (!cs) begin
      nxt = CH_IDLE;
    end else begin
      case (state_q)
        CH_OFF:  nxt = CH_IDLE;
        CH_IDLE: begin
          if (take_card)      nxt = CH_CARD_IN;
          else if (take_host) nxt = CH_HOST_IN;
        end
        CH_HOST_IN: begin
          if (host_ev.rise) begin
            nxt   = CH_IDLE;
            leave = 1'b1;
          end
        end
        CH_CARD_IN: begin
          if (card_ev.rise) begin
            nxt   = CH_IDLE;
            leave = 1'b1;
          end
        end
        default: nxt = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_OFF;
    else        state_q <= nxt;
  end

  arb_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .nxt     (nxt),
    .leave   (leave),
    .host_lo (host_lo),
    .host_hi (host_hi),
    .card_lo (card_lo),
    .card_hi (card_hi)
  );

endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter #(
  parameter int   NUM_CH     = 3,
  parameter logic CARD_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              cs,
  input  logic [NUM_CH-1:0] host_lvl,
  input  logic [NUM_CH-1:0] card_lvl,
  output logic [NUM_CH-1:0] host_pull_lo,
  output logic [NUM_CH-1:0] host_push_hi,
  output logic [NUM_CH-1:0] card_pull_lo,
  output logic [NUM_CH-1:0] card_push_hi
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    arb_channel #(.CARD_FIRST(CARD_FIRST)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .cs       (cs),
      .host_lvl (host_lvl[g]),
      .card_lvl (card_lvl[g]),
      .host_lo  (host_pull_lo[g]),
      .host_hi  (host_push_hi[g]),
      .card_lo  (card_pull_lo[g]),
      .card_hi  (card_push_hi[g])
    );
  end

endmodule

// File: rtl/io_dir_arbiter_chk.sv
module io_dir_arbiter_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              cs,
  input logic [NUM_CH-1:0] host_lvl,
  input logic [NUM_CH-1:0] card_lvl,
  input logic [NUM_CH-1:0] host_pull_lo,
  input logic [NUM_CH-1:0] host_push_hi,
  input logic [NUM_CH-1:0] card_pull_lo,
  input logic [NUM_CH-1:0] card_push_hi
);

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (card_pull_lo == '1 && host_pull_lo == '0 &&
                host_push_hi == '0 && card_push_hi == '0));

  p_cs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !cs) |=> (host_pull_lo == '0 && host_push_hi == '0 &&
                        card_pull_lo == '0 && card_push_hi == '0));

  p_no_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_pull_lo & host_push_hi) | (card_pull_lo & card_push_hi) |
     (host_pull_lo & card_pull_lo)) == '0);

  p_push_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push_hi | card_push_hi) != '0 |=>
      ((host_push_hi & $past(host_push_hi)) |
       (card_push_hi & $past(card_push_hi))) == '0);

  p_push_after_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_push_hi & ~$past(host_pull_lo)) |
     (card_push_hi & ~$past(card_pull_lo))) == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_host_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rx_en && cs && !host_pull_lo[g] && !card_pull_lo[g] &&
       $past(host_lvl[g]) && !host_lvl[g] && $past(card_lvl[g]) && card_lvl[g])
      |=> card_pull_lo[g]);

    p_card_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rx_en && cs && !host_pull_lo[g] && !card_pull_lo[g] &&
       $past(card_lvl[g]) && !card_lvl[g])
      |=> host_pull_lo[g]);
  end

endmodule

bind io_dir_arbiter io_dir_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .cs           (cs),
  .host_lvl     (host_lvl),
  .card_lvl     (card_lvl),
  .host_pull_lo (host_pull_lo),
  .host_push_hi (host_push_hi),
  .card_pull_lo (card_pull_lo),
  .card_push_hi (card_push_hi)
);

// File: tb/io_dir_arbiter_test.sv
module io_dir_arbiter_test;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic rx_en = 1'b0;
  logic cs = 1'b1;
  logic [N-1:0] host_ext = '1;
  logic [N-1:0] card_ext = '1;
  logic [N-1:0] host_lvl, card_lvl;
  logic [N-1:0] host_pull_lo, host_push_hi, card_pull_lo, card_push_hi;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  // Open-drain line model: wired-AND of the outside driver and the block.
  assign host_lvl = host_push_hi | (host_ext & ~host_pull_lo);
  assign card_lvl = card_push_hi | (card_ext & ~card_pull_lo);

  io_dir_arbiter #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cs(cs),
    .host_lvl(host_lvl), .card_lvl(card_lvl),
    .host_pull_lo(host_pull_lo), .host_push_hi(host_push_hi),
    .card_pull_lo(card_pull_lo), .card_push_hi(card_push_hi)
  );

  // Behavioural reference: mode 0 = off, 1 = neutral, 2 = host drives, 3 = card drives.
  int  mode [N];
  bit  h_was [N];
  bit  c_was [N];
  logic [N-1:0] e_hlo, e_hhi, e_clo, e_chi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mode[i] = 0; h_was[i] = 1'b1; c_was[i] = 1'b0;
      end
      e_clo = '1; e_hlo = '0; e_hhi = '0; e_chi = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit hf, cf, hr, cr;
        int nm;
        hf = h_was[i] && !host_lvl[i];
        cf = c_was[i] && !card_lvl[i];
        hr = !h_was[i] && host_lvl[i];
        cr = !c_was[i] && card_lvl[i];
        nm = mode[i];
        if (!rx_en) nm = 0;
        else if (!cs) nm = 1;
        else if (mode[i] == 0) nm = 1;
        else if (mode[i] == 1) nm = cf ? 3 : (hf ? 2 : 1);
        else if (mode[i] == 2 && hr) nm = 1;
        else if (mode[i] == 3 && cr) nm = 1;
        e_clo[i] = (nm == 0) || (nm == 2);
        e_hlo[i] = (nm == 3);
        e_chi[i] = rx_en && cs && mode[i] == 2 && nm == 1;
        e_hhi[i] = rx_en && cs && mode[i] == 3 && nm == 1;
        mode[i] = nm;
        h_was[i] = host_lvl[i];
        c_was[i] = card_lvl[i];
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if ({host_pull_lo, host_push_hi, card_pull_lo, card_push_hi} !==
        {e_hlo, e_hhi, e_clo, e_chi}) begin
      fails++;
      $display("FAIL %s: hlo/hhi/clo/chi actual %b %b %b %b expected %b %b %b %b",
               tag, host_pull_lo, host_push_hi, card_pull_lo, card_push_hi,
               e_hlo, e_hhi, e_clo, e_chi);
    end
    checks++;
    if (((host_pull_lo & host_push_hi) | (card_pull_lo & card_push_hi) |
         (host_pull_lo & card_pull_lo)) !== '0) begin
      fails++;
      $display("FAIL R9: conflicting drives actual hlo=%b hhi=%b clo=%b chi=%b expected no overlap",
               host_pull_lo, host_push_hi, card_pull_lo, card_push_hi);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_vec(input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", t, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    expect_vec("R1", card_pull_lo, '1);
    expect_vec("R1", host_pull_lo, '0);

    tag = "R3"; rx_en = 1'b1; step(4);
    expect_vec("R3", card_pull_lo, '0);

    tag = "R4"; host_ext[0] = 1'b0; step(4);
    expect_vec("R4", card_pull_lo, 3'b001);
    tag = "R7"; host_ext[0] = 1'b1; step(1);
    step(1);
    expect_vec("R7", card_push_hi, '0);
    step(2);

    tag = "R5"; card_ext[1] = 1'b0; step(4);
    expect_vec("R5", host_pull_lo, 3'b010);
    tag = "R7"; card_ext[1] = 1'b1; step(4);

    tag = "R6"; host_ext[2] = 1'b0; card_ext[2] = 1'b0; step(4);
    expect_vec("R6", host_pull_lo, 3'b100);
    card_ext[2] = 1'b1; host_ext[2] = 1'b1; step(4);

    tag = "R8"; cs = 1'b0; step(1);
    host_ext[0] = 1'b0; card_ext[1] = 1'b0; step(4);
    expect_vec("R8", host_pull_lo | card_pull_lo, '0);
    cs = 1'b1; step(4);
    expect_vec("R8", host_pull_lo | card_pull_lo, '0);
    host_ext[0] = 1'b1; card_ext[1] = 1'b1; step(3);

    tag = "R8"; host_ext[2] = 1'b0; step(3);
    cs = 1'b0; step(3);
    expect_vec("R8", card_pull_lo, '0);
    cs = 1'b1; step(3);
    host_ext[2] = 1'b1; step(3);

    tag = "R2"; host_ext[1] = 1'b0; step(3);
    rx_en = 1'b0; step(3);
    expect_vec("R2", card_pull_lo, '1);
    host_ext[1] = 1'b1; step(2);
    rx_en = 1'b1; step(3);

    tag = "R10"; host_ext[0] = 1'b0; step(1);
    card_ext[1] = 1'b0; step(1);
    host_ext[2] = 1'b0; step(2);
    expect_vec("R10", card_pull_lo, 3'b101);
    expect_vec("R10", host_pull_lo, 3'b010);
    host_ext[0] = 1'b1; step(2);
    card_ext[1] = 1'b1; step(1);
    host_ext[2] = 1'b1; step(4);
    for (int k = 0; k < 6; k++) begin
      host_ext = 3'(k); card_ext = 3'(~k); step(3);
      host_ext = '1; card_ext = '1; step(3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule